// File: doc/BRIEF.md
# Interval Down-Counter Timer

This block is a register-mapped timer whose counter is made of two 16-bit halves. With the configuration register at 0 the halves act as one 32-bit down-counter that runs either once (one-shot) or repeatedly (periodic). Software programs it over a flat register bus: a word address, a write strobe, write data and combinational read data. The block drives a level interrupt line and a one-cycle trigger pulse for other logic on the chip.

Register map (word address: use): 0 configuration (bits 2:0), 1 mode for half A (bits 1:0), 2 mode for half B (bits 1:0, stored only), 3 control, 4 interval load (low half, 32-bit view), 5 interval load (high half), 6 current count (low half, 32-bit view), 7 current count (high half), 8 interrupt mask (bit 0), 9 raw time-out status (bit 0), 10 masked status (bit 0), 11 interrupt clear (bit 0), 12 and 13 prescale storage for halves A and B (8 bits each, no effect on counting). Control bits: bit 0 run, bit 1 stall enable, bit 5 trigger enable. Mode codes: 1 one-shot, 2 periodic; codes 0 and 3 leave the counter idle. A configuration value other than 0 leaves the counter idle.

Top module: `interval_timer32`

## Requirements
- R1: After reset the interval load reads 0xFFFF_FFFF at address 4, the count reads 0xFFFF_FFFF at address 6, the prescale registers, control, mask and raw status read 0, and irq and trig are low.
- R2: With configuration 0, a write to address 4 sets the 32-bit interval value; address 5 then reads bits 31:16 of that write and address 4 reads the whole word.
- R3: With configuration 0, address 6 reads the high count half in bits 31:16 and the low half in bits 15:0, with a borrow carried across the halves while counting.
- R4: A write to address 4 with configuration 0 also loads the count; once the run bit is set, the count falls by one per clock from that value.
- R5: At the clock after the count is zero while counting, the count takes the full 32-bit interval value.
- R6: In one-shot mode the run bit clears itself at that reload and the count stays at the interval value; in periodic mode the run bit stays set and counting goes on.
- R7: Each time-out sets the raw status bit, which stays set until a write with bit 0 set to address 11; a clear landing on the same clock as a time-out leaves the bit set.
- R8: The masked status at address 10 and the irq output are the raw status ANDed with mask bit 0.
- R9: trig is high for the one cycle after each time-out, and only when control bit 5 is set.
- R10: A write to address 4 while counting replaces the count at the next clock, and counting continues down from the new value.
- R11: While control bit 1 is set and stall_in is high the count holds; with control bit 1 clear, stall_in has no effect.
- R12: The one-shot or periodic choice comes only from the half A mode at address 1; the half B mode is ignored, and with configuration 1 the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| stall_in | input | 1 | Freeze request, honoured when control bit 1 is set |
| irq | output | 1 | Level interrupt, raw status AND mask |
| trig | output | 1 | One-cycle time-out pulse, gated by control bit 5 |

## Verification
Two pairs of events can share one clock: a time-out and a software clear of the raw status, and a time-out and a one-shot self-clear of the run bit. The bench watches the count until it reads zero and then issues the clear write so that it commits on the time-out edge, expecting the status to remain set, and a later clear on an ordinary cycle to drop it. A sweep over small interval values in both modes, with and without the trigger, compares count, status, run bit, irq and trig each cycle against values computed from the interval length.

// File: rtl/interval_timer32.sv
module interval_timer32 #(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] rdata,
  input  logic              stall_in,
  output logic              irq,
  output logic              trig
);
  localparam int W = 2 * HALF_W;
  localparam logic [AW-1:0] A_CFG = 0, A_MODE_A = 1, A_MODE_B = 2, A_CTRL = 3,
                            A_LOAD_LO = 4, A_LOAD_HI = 5, A_CNT_LO = 6, A_CNT_HI = 7,
                            A_MASK = 8, A_RAW = 9, A_MSK_ST = 10, A_CLR = 11,
                            A_PRE_A = 12, A_PRE_B = 13;
  localparam logic [1:0] M_ONESHOT = 2'd1, M_PERIODIC = 2'd2;

  logic [2:0]        cfg;
  logic [1:0]        mode_a, mode_b;
  logic              run, stall_en, trig_en;
  logic [HALF_W-1:0] load_lo, load_hi;
  logic [W-1:0]      cnt;
  logic              mask, raw, trig_q;
  logic [PRE_W-1:0]  pre_a, pre_b;

  wire wide    = (cfg == 3'd0);
  wire mode_ok = (mode_a == M_ONESHOT) || (mode_a == M_PERIODIC);
  wire stalled = stall_en && stall_in;
  wire active  = wide && run && mode_ok && !stalled;
  wire tmo     = active && (cnt == '0);
  wire load_wr = wr_en && (addr == A_LOAD_LO) && wide;
  wire ctrl_wr = wr_en && (addr == A_CTRL);
  wire clr_wr  = wr_en && (addr == A_CLR) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      mode_a   <= '0;
      mode_b   <= '0;
      stall_en <= 1'b0;
      trig_en  <= 1'b0;
      load_lo  <= '1;
      load_hi  <= '1;
      mask     <= 1'b0;
      pre_a    <= '0;
      pre_b    <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CFG:     cfg <= wdata[2:0];
        A_MODE_A:  mode_a <= wdata[1:0];
        A_MODE_B:  mode_b <= wdata[1:0];
        A_CTRL:    begin stall_en <= wdata[1]; trig_en <= wdata[5]; end
        A_LOAD_LO: begin
          load_lo <= wdata[HALF_W-1:0];
          if (wide) load_hi <= wdata[W-1:HALF_W];
        end
        A_LOAD_HI: load_hi <= wdata[HALF_W-1:0];
        A_MASK:    mask <= wdata[0];
        A_PRE_A:   pre_a <= wdata[PRE_W-1:0];
        A_PRE_B:   pre_b <= wdata[PRE_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '1;
      raw    <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (tmo && mode_a == M_ONESHOT) run <= 1'b0;
      else if (ctrl_wr)               run <= wdata[0];

      if (load_wr)     cnt <= wdata;
      else if (tmo)    cnt <= {load_hi, load_lo};
      else if (active) cnt <= cnt - 1'b1;

      if (tmo)         raw <= 1'b1;
      else if (clr_wr) raw <= 1'b0;

      trig_q <= tmo && trig_en;
    end
  end

  assign irq  = raw & mask;
  assign trig = trig_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG:     rdata[2:0] = cfg;
      A_MODE_A:  rdata[1:0] = mode_a;
      A_MODE_B:  rdata[1:0] = mode_b;
      A_CTRL:    begin rdata[0] = run; rdata[1] = stall_en; rdata[5] = trig_en; end
      A_LOAD_LO: rdata = wide ? {load_hi, load_lo} : {{HALF_W{1'b0}}, load_lo};
      A_LOAD_HI: rdata[HALF_W-1:0] = load_hi;
      A_CNT_LO:  rdata = wide ? cnt : {{HALF_W{1'b0}}, cnt[HALF_W-1:0]};
      A_CNT_HI:  rdata[HALF_W-1:0] = cnt[W-1:HALF_W];
      A_MASK:    rdata[0] = mask;
      A_RAW:     rdata[0] = raw;
      A_MSK_ST:  rdata[0] = irq;
      A_PRE_A:   rdata[PRE_W-1:0] = pre_a;
      A_PRE_B:   rdata[PRE_W-1:0] = pre_b;
      default:   rdata = '0;
    endcase
  end

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0 && !load_wr) |=> cnt == $past(cnt) - 1'b1);
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !load_wr) |=> cnt == $past({load_hi, load_lo}));
  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && mode_a == M_ONESHOT) |=> !run);
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> raw);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !clr_wr) |=> raw);
  a_r9_trig_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(tmo && trig_en));
  a_r10_load_now: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> cnt == $past(wdata));
  a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !load_wr) |=> $stable(cnt));
  a_r12_idle_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != 3'd0) |=> $stable(cnt));
endmodule

// File: tb/interval_timer32_test.sv
module interval_timer32_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        stall_in = 1'b0;
  logic        irq, trig;

  int ntot = 0;
  int nfail = 0;
  bit done = 0;

  interval_timer32 uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .stall_in(stall_in), .irq(irq), .trig(trig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic prep(input logic [31:0] load, input logic [1:0] mode);
    wr(4'd3, 32'h0);
    wr(4'd4, load);
    wr(4'd11, 32'h1);
    wr(4'd1, {30'b0, mode});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd4, v);  chk("R1 load", v, 32'hFFFF_FFFF);
    rd(4'd6, v);  chk("R1 count", v, 32'hFFFF_FFFF);
    rd(4'd12, v); chk("R1 prescale A", v, 0);
    rd(4'd13, v); chk("R1 prescale B", v, 0);
    rd(4'd3, v);  chk("R1 control", v, 0);
    rd(4'd8, v);  chk("R1 mask", v, 0);
    rd(4'd9, v);  chk("R1 raw", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 trig", {31'b0, trig}, 0);

    // R2 stitched load write
    wr(4'd4, 32'hABCD_1234);
    rd(4'd5, v); chk("R2 high half", v, 32'h0000_ABCD);
    rd(4'd4, v); chk("R2 full word", v, 32'hABCD_1234);
    rd(4'd6, v); chk("R4 count follows load", v, 32'hABCD_1234);

    // R3 concatenated count with borrow
    prep(32'h0001_0000, 2'd2);
    wr(4'd3, 32'h1);
    rd(4'd6, v); chk("R3 count start", v, 32'h0001_0000);
    rd(4'd7, v); chk("R3 high half read", v, 32'h0000_0001);
    tick(1);
    rd(4'd6, v); chk("R3 borrow across halves", v, 32'h0000_FFFF);
    rd(4'd7, v); chk("R3 high half after borrow", v, 0);

    // R4 R5 R6 R7 R8 R9 sweep
    for (int m = 1; m <= 2; m++) begin
      for (int te = 0; te <= 1; te++) begin
        for (int L = 0; L <= 5; L++) begin
          prep(L, m[1:0]);
          wr(4'd8, te);
          wr(4'd3, (te << 5) | 1);
          for (int k = 0; k <= 2*L + 4; k++) begin
            logic [31:0] ec;
            logic er, et, erun;
            er = (k >= L + 1);
            if (m == 2) begin
              ec = L - (k % (L + 1));
              et = (te == 1) && (k > 0) && (k % (L + 1) == 0);
              erun = 1'b1;
            end else begin
              ec = (k <= L) ? L - k : L;
              et = (te == 1) && (k == L + 1);
              erun = (k <= L);
            end
            chk("R9 trig", {31'b0, trig}, {31'b0, et});
            chk("R8 irq", {31'b0, irq}, {31'b0, er & te[0]});
            rd(4'd6, v); chk("R5 count", v, ec);
            rd(4'd9, v); chk("R7 raw", v, {31'b0, er});
            rd(4'd3, v); chk("R6 run bit", {31'b0, v[0]}, {31'b0, erun});
            tick(1);
          end
        end
      end
    end

    // R7 clear on same clock as a time-out
    prep(32'd4, 2'd2);
    wr(4'd3, 32'h1);
    tick(6);
    rd(4'd9, v); chk("R7 raw after first time-out", v, 1);
    wr(4'd11, 32'h1);
    rd(4'd9, v); chk("R7 clear on quiet cycle", v, 0);
    rd(4'd6, v);
    while (v != 0) begin tick(1); rd(4'd6, v); end
    wr(4'd11, 32'h1);
    rd(4'd9, v); chk("R7 time-out wins over clear", v, 1);
    wr(4'd11, 32'h0);
    rd(4'd9, v); chk("R7 zero write keeps raw", v, 1);

    // R8 mask
    wr(4'd8, 32'h0);
    rd(4'd10, v); chk("R8 masked status off", v, 0);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(4'd8, 32'h1);
    rd(4'd10, v); chk("R8 masked status on", v, 1);
    chk("R8 irq unmasked", {31'b0, irq}, 1);

    // R10 load while running
    prep(32'd1000, 2'd2);
    wr(4'd3, 32'h1);
    tick(3);
    wr(4'd4, 32'd50);
    rd(4'd6, v); chk("R10 new value next clock", v, 50);
    tick(1);
    rd(4'd6, v); chk("R10 continues from new value", v, 49);

    // R11 stall
    wr(4'd3, 32'h3);
    rd(4'd6, c0);
    stall_in = 1'b1;
    tick(4);
    rd(4'd6, v); chk("R11 stalled count holds", v, c0);
    stall_in = 1'b0;
    tick(2);
    rd(4'd6, v); chk("R11 resumes", v, c0 - 2);
    wr(4'd3, 32'h1);
    rd(4'd6, c0);
    stall_in = 1'b1;
    tick(3);
    rd(4'd6, v); chk("R11 stall ignored when disabled", v, c0 - 3);
    stall_in = 1'b0;

    // R12 half B mode ignored
    prep(32'd2, 2'd2);
    wr(4'd2, 32'd1);
    wr(4'd3, 32'h1);
    tick(6);
    rd(4'd3, v); chk("R12 periodic despite half B one-shot", {31'b0, v[0]}, 1);
    prep(32'd2, 2'd1);
    wr(4'd2, 32'd2);
    wr(4'd3, 32'h1);
    tick(4);
    rd(4'd3, v); chk("R12 one-shot despite half B periodic", {31'b0, v[0]}, 0);

    // R12 configuration 1 idle
    prep(32'd20, 2'd2);
    wr(4'd0, 32'd1);
    wr(4'd3, 32'h1);
    rd(4'd6, c0);
    tick(5);
    rd(4'd6, v); chk("R12 configuration 1 holds count", v, c0);
    wr(4'd0, 32'd0);
    tick(1);
    rd(4'd6, v); chk("R12 configuration 0 resumes", v, 32'd19);

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule